// File: doc/BRIEF.md
# Inline Word Upload Engine

This engine sits behind a command processor and receives register writes as (method index, 32-bit value) pairs. It keeps the small set of method registers that govern an upload: a 64-bit destination base made from a high word and a low word, a launch register whose bit 0 marks the upload as linear, and three destination offsets for x, y and z. Every word written to the push register becomes one 32-bit store on a valid/ready memory request port.

The store goes to the base plus four times a word cursor, and the cursor then steps by one. A write to the launch register returns the cursor to zero, so software writes the base, writes the launch register once, and then streams words into the push register. While a store waits for the memory side to accept it, the command port is held not-ready, so no pushed word is ever dropped.

Two kinds of command are refused. One is a push made while the upload is not linear or while any of x, y or z is nonzero. The other is a method index outside the 127-entry register space. Either one sets a sticky error output and leaves the memory port untouched.

Top module: `upl_engine`

## Requirements
- R1: After reset, mem_req_valid and err_flag are 0 and cmd_ready is 1.
- R2: A push (method 0x6D) with the launch bit set and x, y and z all zero issues exactly one store. Its mem_req_data is the pushed value and its mem_req_addr is {base_hi, base_lo} + 4 * cursor. base_hi is method 0x62 and base_lo is method 0x63.
- R3: Each store advances the cursor by one, so consecutive pushes target consecutive 32-bit words.
- R4: Any write to the launch register (method 0x6C) sets the cursor to zero, and bit 0 of the value written there is the linear flag.
- R5: A push while the linear flag is 0 makes no store and sets err_flag.
- R6: A push while z (0x69), x (0x6A) or y (0x6B) holds a nonzero value makes no store and sets err_flag.
- R7: A command whose method index is 0x7F or higher changes no register, makes no store, and sets err_flag.
- R8: err_flag stays 1 until reset, and valid pushes issued afterwards still store normally.
- R9: While mem_req_valid is 1 and mem_req_ready is 0, the request address and data hold steady and cmd_ready is 0.
- R10: The address sum carries across the boundary between the low and high 32-bit words.
- R11: Writes to other in-range methods (for example 0x61 or 0x64) are accepted without error and change neither the store address nor the cursor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Register write offered |
| cmd_ready | output | 1 | Register write can be taken this cycle |
| cmd_method | input | METHOD_W | Method (register) index |
| cmd_data | input | 32 | Value written |
| mem_req_valid | output | 1 | Store request pending |
| mem_req_ready | input | 1 | Memory side takes the store |
| mem_req_addr | output | 64 | Byte address of the store |
| mem_req_data | output | 32 | Word stored |
| err_flag | output | 1 | Sticky error indication |

## Verification
Pushes are sent as plain runs at one base, as runs split by a second launch write, and as runs with the memory side stalled. These cases separate a cursor that steps from one that is reset, and show whether the request is held under backpressure. A base just below a 4 GiB boundary shows whether the carry into the high word is propagated. Pushes are also made with the linear bit clear, with each offset nonzero, and after writes to out-of-range indices that alias a base register when truncated. These show that refused commands leave stores and registers unchanged, and they separate a sticky error from one that clears by itself. A behavioural model runs alongside and compares cmd_ready, the pending request and err_flag on every clock.

// File: rtl/upl_pkg.sv
package upl_pkg;
    localparam int unsigned REG_SPACE  = 'h7F;
    localparam int unsigned IDX_BASE_HI = 'h62;
    localparam int unsigned IDX_BASE_LO = 'h63;
    localparam int unsigned IDX_OFS_Z   = 'h69;
    localparam int unsigned IDX_OFS_X   = 'h6A;
    localparam int unsigned IDX_OFS_Y   = 'h6B;
    localparam int unsigned IDX_LAUNCH  = 'h6C;
    localparam int unsigned IDX_PUSH    = 'h6D;

    typedef struct packed {
        logic in_range;
        logic base_hi;
        logic base_lo;
        logic ofs_x;
        logic ofs_y;
        logic ofs_z;
        logic launch;
        logic push;
    } upl_hit_t;
endpackage

// File: rtl/upl_method_decode.sv
module upl_method_decode
    import upl_pkg::*;
#(
    parameter int METHOD_W = 12
) (
    input  logic [METHOD_W-1:0] method,
    output upl_hit_t            hit
);
    localparam logic [METHOD_W-1:0] LIM = METHOD_W'(REG_SPACE);

    always_comb begin
        hit.in_range = method < LIM;
        hit.base_hi  = method == METHOD_W'(IDX_BASE_HI);
        hit.base_lo  = method == METHOD_W'(IDX_BASE_LO);
        hit.ofs_x    = method == METHOD_W'(IDX_OFS_X);
        hit.ofs_y    = method == METHOD_W'(IDX_OFS_Y);
        hit.ofs_z    = method == METHOD_W'(IDX_OFS_Z);
        hit.launch   = method == METHOD_W'(IDX_LAUNCH);
        hit.push     = method == METHOD_W'(IDX_PUSH);
    end
endmodule

// File: rtl/upl_addr_gen.sv
module upl_addr_gen #(
    parameter int CURSOR_W = 16
) (
    input  logic [31:0]         base_hi,
    input  logic [31:0]         base_lo,
    input  logic [CURSOR_W-1:0] cursor,
    output logic [63:0]         addr
);
    localparam int PAD_W = 64 - CURSOR_W - 2;

    logic [63:0] byte_ofs;

    always_comb begin
        byte_ofs = {{PAD_W{1'b0}}, cursor, 2'b00};
        addr     = {base_hi, base_lo} + byte_ofs;
    end
endmodule

// File: rtl/upl_store_slot.sv
module upl_store_slot (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [63:0] load_addr,
    input  logic [31:0] load_data,
    input  logic        mem_ready,
    output logic        valid,
    output logic [63:0] addr,
    output logic [31:0] data
);
    typedef struct packed {
        logic        valid;
        logic [63:0] addr;
        logic [31:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.valid && mem_ready) begin
            slot_d.valid = 1'b0;
        end
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.addr  = load_addr;
            slot_d.data  = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid = slot_q.valid;
    assign addr  = slot_q.addr;
    assign data  = slot_q.data;
endmodule

// File: rtl/upl_engine.sv
module upl_engine
    import upl_pkg::*;
#(
    parameter int METHOD_W = 12,
    parameter int CURSOR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [METHOD_W-1:0] cmd_method,
    input  logic [31:0]         cmd_data,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [63:0]         mem_req_addr,
    output logic [31:0]         mem_req_data,
    output logic                err_flag
);
    typedef struct packed {
        logic [31:0]         base_hi;
        logic [31:0]         base_lo;
        logic [31:0]         ofs_x;
        logic [31:0]         ofs_y;
        logic [31:0]         ofs_z;
        logic                linear;
        logic [CURSOR_W-1:0] cursor;
        logic                err;
    } eng_t;

    eng_t        st_d, st_q;
    upl_hit_t    hit;
    logic        accept;
    logic        store_load;
    logic [63:0] next_addr;
    logic        slot_busy;

    upl_method_decode #(.METHOD_W(METHOD_W)) u_dec (
        .method (cmd_method),
        .hit    (hit)
    );

    upl_addr_gen #(.CURSOR_W(CURSOR_W)) u_agen (
        .base_hi (st_q.base_hi),
        .base_lo (st_q.base_lo),
        .cursor  (st_q.cursor),
        .addr    (next_addr)
    );

    assign cmd_ready = !slot_busy;
    assign accept    = cmd_valid && cmd_ready;

    always_comb begin
        st_d       = st_q;
        store_load = 1'b0;
        if (accept) begin
            if (!hit.in_range) begin
                st_d.err = 1'b1;
            end else begin
                if (hit.base_hi) st_d.base_hi = cmd_data;
                if (hit.base_lo) st_d.base_lo = cmd_data;
                if (hit.ofs_x)   st_d.ofs_x   = cmd_data;
                if (hit.ofs_y)   st_d.ofs_y   = cmd_data;
                if (hit.ofs_z)   st_d.ofs_z   = cmd_data;
                if (hit.launch) begin
                    st_d.linear = cmd_data[0];
                    st_d.cursor = '0;
                end
                if (hit.push) begin
                    if (st_q.linear && (st_q.ofs_x == '0) &&
                        (st_q.ofs_y == '0) && (st_q.ofs_z == '0)) begin
                        store_load  = 1'b1;
                        st_d.cursor = st_q.cursor + 1'b1;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    upl_store_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (store_load),
        .load_addr (next_addr),
        .load_data (cmd_data),
        .mem_ready (mem_req_ready),
        .valid     (slot_busy),
        .addr      (mem_req_addr),
        .data      (mem_req_data)
    );

    assign mem_req_valid = slot_busy;
    assign err_flag      = st_q.err;
endmodule

// File: rtl/upl_engine_checker.sv
module upl_engine_checker #(
    parameter int METHOD_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [METHOD_W-1:0] cmd_method,
    input logic [31:0]         cmd_data,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic [63:0]         mem_req_addr,
    input logic [31:0]         mem_req_data,
    input logic                err_flag
);
    localparam logic [METHOD_W-1:0] PUSH_IDX = METHOD_W'('h6D);
    localparam logic [METHOD_W-1:0] LIM_IDX  = METHOD_W'('h7F);

    // R9: request held under backpressure
    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)));

    // R9: command port closed while a store is pending
    a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cmd_ready);

    // R8: error is sticky
    a_r8_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R2: an accepted push yields a store of its value or an error
    a_r2_push_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_method == PUSH_IDX) |=>
            ((mem_req_valid && mem_req_data == $past(cmd_data)) || err_flag));

    // R7: out-of-range index raises the error and stores nothing
    a_r7_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_method >= LIM_IDX) |=>
            (err_flag && !mem_req_valid));
endmodule

bind upl_engine upl_engine_checker #(.METHOD_W(METHOD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_method    (cmd_method),
    .cmd_data      (cmd_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_data  (mem_req_data),
    .err_flag      (err_flag)
);

// File: tb/upl_engine_bench.sv
`timescale 1ns/1ps
module upl_engine_bench;
    localparam int MW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [MW-1:0] cmd_method = '0;
    logic [31:0]   cmd_data = '0;
    logic          mem_req_valid;
    logic          mem_rdy = 1'b1;
    logic [63:0]   mem_req_addr;
    logic [31:0]   mem_req_data;
    logic          err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    upl_engine #(.METHOD_W(MW), .CURSOR_W(16)) u_upl_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_method    (cmd_method),
        .cmd_data      (cmd_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_rdy),
        .mem_req_addr  (mem_req_addr),
        .mem_req_data  (mem_req_data),
        .err_flag      (err_flag)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_hi, m_lo, m_x, m_y, m_z;
    bit          m_lin, m_pend, m_err;
    int unsigned m_cur;
    logic [63:0] m_addr;
    logic [31:0] m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_x = 0; m_y = 0; m_z = 0;
            m_lin = 0; m_pend = 0; m_err = 0; m_cur = 0;
            m_addr = 0; m_data = 0;
        end else if (m_pend) begin
            if (mem_rdy) m_pend = 0;
        end else if (cmd_valid) begin
            int m;
            m = int'(cmd_method);
            if (m >= 127) m_err = 1;
            else begin
                case (m)
                    'h62: m_hi = cmd_data;
                    'h63: m_lo = cmd_data;
                    'h69: m_z = cmd_data;
                    'h6A: m_x = cmd_data;
                    'h6B: m_y = cmd_data;
                    'h6C: begin m_lin = cmd_data[0]; m_cur = 0; end
                    'h6D: begin
                        if (m_lin && m_x == 0 && m_y == 0 && m_z == 0) begin
                            m_pend = 1;
                            m_addr = {m_hi, m_lo} + 64'(m_cur % 65536) * 64'd4;
                            m_data = cmd_data;
                            m_cur++;
                        end else m_err = 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cmd_ready == !m_pend, "R9 ready", 64'(cmd_ready), 64'(!m_pend));
            chk(mem_req_valid == m_pend, "R2 valid", 64'(mem_req_valid), 64'(m_pend));
            if (m_pend && mem_req_valid) begin
                chk(mem_req_addr == m_addr, "R2 addr", mem_req_addr, m_addr);
                chk(mem_req_data == m_data, "R2 data", 64'(mem_req_data), 64'(m_data));
            end
            chk(err_flag == m_err, "R8 err", 64'(err_flag), 64'(m_err));
        end
    end

    // observed stores
    logic [63:0] obs_a[$];
    logic [31:0] obs_d[$];
    always @(posedge clk) begin
        if (rst_n && mem_req_valid && mem_rdy) begin
            obs_a.push_back(mem_req_addr);
            obs_d.push_back(mem_req_data);
        end
    end

    task automatic send(input int m, input logic [31:0] v);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_method = MW'(m);
        cmd_data   = v;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        obs_a.delete();
        obs_d.delete();
    endtask

    task automatic expect_store(input int idx, input logic [63:0] a,
                                input logic [31:0] d, input string tag);
        if (idx >= obs_a.size()) begin
            chk(1'b0, tag, 64'(obs_a.size()), 64'(idx + 1));
        end else begin
            chk(obs_a[idx] == a, tag, obs_a[idx], a);
            chk(obs_d[idx] == d, tag, 64'(obs_d[idx]), 64'(d));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(cmd_ready == 1'b1, "R1 ready", 64'(cmd_ready), 64'd1);
        chk(mem_req_valid == 1'b0, "R1 valid", 64'(mem_req_valid), 64'd0);
        chk(err_flag == 1'b0, "R1 err", 64'(err_flag), 64'd0);

        // R2 R3: consecutive words
        send('h62, 32'h1);
        send('h63, 32'h1000_0000);
        send('h6C, 32'h1);
        send('h6D, 32'hA0A0_0001);
        send('h6D, 32'hA0A0_0002);
        send('h6D, 32'hA0A0_0003);
        settle();
        expect_store(0, 64'h1_1000_0000, 32'hA0A0_0001, "R2 first store");
        expect_store(1, 64'h1_1000_0004, 32'hA0A0_0002, "R3 second word");
        expect_store(2, 64'h1_1000_0008, 32'hA0A0_0003, "R3 third word");

        // R4: launch resets cursor
        send('h6C, 32'h1);
        send('h6D, 32'hB000_0001);
        settle();
        expect_store(3, 64'h1_1000_0000, 32'hB000_0001, "R4 cursor reset");

        // R9: backpressure
        mem_rdy = 1'b0;
        send('h6D, 32'hC000_0001);
        repeat (5) @(negedge clk);
        chk(mem_req_valid == 1'b1, "R9 held valid", 64'(mem_req_valid), 64'd1);
        chk(cmd_ready == 1'b0, "R9 ready low", 64'(cmd_ready), 64'd0);
        chk(mem_req_addr == 64'h1_1000_0004, "R9 held addr", mem_req_addr, 64'h1_1000_0004);
        mem_rdy = 1'b1;
        settle();
        expect_store(4, 64'h1_1000_0004, 32'hC000_0001, "R9 store after stall");

        // R11: other in-range methods
        send('h61, 32'h5);
        send('h64, 32'hFF);
        send('h67, 32'h33);
        send('h6D, 32'hD000_0001);
        settle();
        chk(err_flag == 1'b0, "R11 no error", 64'(err_flag), 64'd0);
        expect_store(5, 64'h1_1000_0008, 32'hD000_0001, "R11 cursor unchanged");

        // R10: carry into high word
        send('h62, 32'h2);
        send('h63, 32'hFFFF_FFFC);
        send('h6C, 32'h1);
        send('h6D, 32'hE000_0001);
        send('h6D, 32'hE000_0002);
        settle();
        expect_store(6, 64'h2_FFFF_FFFC, 32'hE000_0001, "R10 below boundary");
        expect_store(7, 64'h3_0000_0000, 32'hE000_0002, "R10 carry");

        // R5: non-linear push refused; R8 sticky
        do_reset();
        send('h62, 32'h0);
        send('h63, 32'h4000);
        send('h6C, 32'h0);
        send('h6D, 32'h1111_1111);
        settle();
        chk(obs_a.size() == 0, "R5 no store", 64'(obs_a.size()), 64'd0);
        chk(err_flag == 1'b1, "R5 error set", 64'(err_flag), 64'd1);
        send('h6C, 32'h1);
        send('h6D, 32'h2222_2222);
        settle();
        chk(err_flag == 1'b1, "R8 still set", 64'(err_flag), 64'd1);
        expect_store(0, 64'h4000, 32'h2222_2222, "R8 store after error");

        // R6: nonzero offsets
        do_reset();
        send('h63, 32'h8000);
        send('h6C, 32'h1);
        send('h6A, 32'h3);
        send('h6D, 32'h3333_0001);
        settle();
        chk(obs_a.size() == 0, "R6 x refused", 64'(obs_a.size()), 64'd0);
        chk(err_flag == 1'b1, "R6 error", 64'(err_flag), 64'd1);
        send('h6A, 32'h0);
        send('h69, 32'h1);
        send('h6D, 32'h3333_0002);
        settle();
        chk(obs_a.size() == 0, "R6 z refused", 64'(obs_a.size()), 64'd0);
        send('h69, 32'h0);
        send('h6B, 32'h7);
        send('h6D, 32'h3333_0003);
        settle();
        chk(obs_a.size() == 0, "R6 y refused", 64'(obs_a.size()), 64'd0);
        send('h6B, 32'h0);
        send('h6D, 32'h3333_0004);
        settle();
        expect_store(0, 64'h8000, 32'h3333_0004, "R6 cleared offsets store");

        // R7: out-of-range indices ignored
        do_reset();
        send('h62, 32'h5);
        send('h63, 32'h100);
        send('h6C, 32'h1);
        send('h7F, 32'h9);
        settle();
        chk(err_flag == 1'b1, "R7 error", 64'(err_flag), 64'd1);
        chk(mem_req_valid == 1'b0, "R7 no store", 64'(mem_req_valid), 64'd0);
        send('h162, 32'hDEAD);
        send('h16C, 32'h1);
        send('h6D, 32'h7777_0001);
        send('h1EC, 32'h0);
        send('h6D, 32'h7777_0002);
        settle();
        expect_store(0, 64'h5_0000_0100, 32'h7777_0001, "R7 base kept");
        expect_store(1, 64'h5_0000_0104, 32'h7777_0002, "R7 cursor kept");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule